// File: doc/BRIEF.md
# Run-time Configurable Sum-of-Products Array

This block evaluates a set of sum-of-products functions whose structure is held in configuration flops instead of being fixed at design time. Each data input is offered to a product-term row as a true literal and as an inverted literal. A product term is the AND of whichever literals its row selects. Each output is the OR of whichever product terms its column selects. Both planes are programmable, so a product term needed by several functions is built once and wired into all of them.

The configuration is a single chain of flops. It is loaded one bit per clock through a serial input while a load enable is held high. While loading is in progress the outputs stay at zero. Once the enable drops, the chain holds its contents and the data path from inputs to outputs is purely combinational. The defaults are three inputs, five product terms and four outputs, which gives 50 configuration bits.

Top module: `cfg_pla`

## Requirements
- R1: A product term that selects only the inverted literal of input i equals the inverse of input i, so every input is usable in both polarities.
- R2: A product term equals the AND of all literals its row selects. Row p, input i, true literal sits at chain index p*2*N_IN + 2*i, and the inverted literal at p*2*N_IN + 2*i + 1.
- R3: A product term whose row selects no literal evaluates to 1.
- R4: A product term that selects both the true and the inverted literal of the same input evaluates to 0.
- R5: An output equals the OR of the product terms its column selects. Output o, term p sits at chain index N_PT*2*N_IN + o*N_PT + p.
- R6: An output whose column selects no product term is 0.
- R7: One product term may be selected by several outputs at once, and each of those outputs follows it.
- R8: While cfg_en is high, each rising clock edge shifts cfg_si into the top of the chain and moves every bit down by one index. Chain index 0 is therefore the bit presented first, and index CFG_W-1 the bit presented last, after exactly CFG_W shifts.
- R9: While cfg_en is high, every output is 0.
- R10: An active-low reset clears every configuration bit, so all outputs are 0 after reset until a new configuration is loaded.
- R11: While cfg_en is low, the configuration does not change, whatever cfg_si does, and the outputs follow pla_in with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset; clears the configuration |
| cfg_en | input | 1 | Load enable; shifts the chain and mutes the outputs while high |
| cfg_si | input | 1 | Serial configuration bit, index 0 presented first |
| pla_in | input | N_IN | Data inputs to the product-term rows |
| pla_out | output | N_OUT | Sum-of-products results |

## Verification
The only registered path is the configuration chain. One bit enters at each rising edge while cfg_en is high. A pattern of CFG_W bits is therefore complete at the edge after the last bit is driven, and the outputs reflect it as soon as cfg_en falls. The bench drives every input on a falling edge. It checks the outputs one nanosecond later, after each change of pla_in, cfg_en or rst_n, because all data results are combinational and due in the same cycle. The mute check during loading is sampled midway through the chain. The retention check runs after twenty clocks of toggling cfg_si with the enable low, so any unwanted shift would have reached the outputs.

// File: rtl/pla_pkg.sv
package pla_pkg;

    // Chain index of a literal select bit in the product-term plane.
    // neg = 0 selects the true literal, neg = 1 the inverted one.
    function automatic int and_bit_idx(input int n_in, input int pt,
                                       input int inp, input int neg);
        return pt * 2 * n_in + 2 * inp + neg;
    endfunction

    // Chain index of a term select bit in the output plane.
    function automatic int or_bit_idx(input int n_in, input int n_pt,
                                      input int out, input int pt);
        return n_pt * 2 * n_in + out * n_pt + pt;
    endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
    parameter int W = 50
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         shift_in,
    output logic [W-1:0] bits
);

    typedef struct packed {
        logic [W-1:0] bits;
    } chain_t;

    chain_t chain_d;
    chain_t chain_q;

    always_comb begin
        chain_d = chain_q;
        if (shift_en) begin
            chain_d.bits = {shift_in, chain_q.bits[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign bits = chain_q.bits;

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN = 3,
    parameter int N_PT = 5,
    localparam int ROW_W = 2 * N_IN,
    localparam int SEL_W = N_PT * ROW_W
) (
    input  logic [N_IN-1:0]  lit_in,
    input  logic [SEL_W-1:0] sel,
    output logic [N_PT-1:0]  term
);

    // Literal vector: even slots carry the true input, odd slots the inverse.
    logic [ROW_W-1:0] lits;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[2*i]     = lit_in[i];
        assign lits[2*i + 1] = ~lit_in[i];
    end

    // An unselected literal contributes 1; an empty row is therefore 1.
    for (genvar p = 0; p < N_PT; p++) begin : g_row
        logic [ROW_W-1:0] row_sel;
        assign row_sel = sel[p*ROW_W +: ROW_W];
        assign term[p] = &(~row_sel | lits);
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_PT  = 5,
    parameter int N_OUT = 4,
    localparam int SEL_W = N_OUT * N_PT
) (
    input  logic [N_PT-1:0]  term,
    input  logic [SEL_W-1:0] sel,
    output logic [N_OUT-1:0] sum
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_col
        logic [N_PT-1:0] col_sel;
        assign col_sel = sel[o*N_PT +: N_PT];
        assign sum[o]  = |(col_sel & term);
    end

endmodule

// File: rtl/cfg_pla.sv
module cfg_pla #(
    parameter int N_IN  = 3,
    parameter int N_PT  = 5,
    parameter int N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_si,
    input  logic [N_IN-1:0]  pla_in,
    output logic [N_OUT-1:0] pla_out
);

    localparam int AND_W = N_PT * 2 * N_IN;
    localparam int OR_W  = N_OUT * N_PT;
    localparam int CFG_W = AND_W + OR_W;

    logic [CFG_W-1:0] cfg_bits;
    logic [N_PT-1:0]  pt_vec;
    logic [N_OUT-1:0] sum_vec;

    pla_cfg_chain #(
        .W (CFG_W)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .shift_in (cfg_si),
        .bits     (cfg_bits)
    );

    pla_and_plane #(
        .N_IN (N_IN),
        .N_PT (N_PT)
    ) u_and (
        .lit_in (pla_in),
        .sel    (cfg_bits[AND_W-1:0]),
        .term   (pt_vec)
    );

    pla_or_plane #(
        .N_PT  (N_PT),
        .N_OUT (N_OUT)
    ) u_or (
        .term (pt_vec),
        .sel  (cfg_bits[CFG_W-1:AND_W]),
        .sum  (sum_vec)
    );

    // Partially shifted patterns never reach the outputs.
    assign pla_out = cfg_en ? '0 : sum_vec;

endmodule

// File: rtl/pla_checker.sv
module pla_checker #(
    parameter int N_IN  = 3,
    parameter int N_PT  = 5,
    parameter int N_OUT = 4,
    localparam int AND_W = N_PT * 2 * N_IN,
    localparam int CFG_W = AND_W + N_OUT * N_PT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             cfg_si,
    input logic [N_IN-1:0]  pla_in,
    input logic [N_OUT-1:0] pla_out,
    input logic [CFG_W-1:0] cfg_bits,
    input logic [N_PT-1:0]  pt_vec
);
    import pla_pkg::*;

    AST_LOAD_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (pla_out == '0)); // R9

    AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_bits)); // R11

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cfg_bits[CFG_W-1] == $past(cfg_si))); // R8

    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cfg_bits[CFG_W-2:0] == $past(cfg_bits[CFG_W-1:1]))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_bits == '0)); // R10

    for (genvar p = 0; p < N_PT; p++) begin : g_term_chk
        logic [N_IN-1:0] true_sel;
        logic [N_IN-1:0] inv_sel;
        for (genvar i = 0; i < N_IN; i++) begin : g_lit_chk
            assign true_sel[i] = cfg_bits[and_bit_idx(N_IN, p, i, 0)];
            assign inv_sel[i]  = cfg_bits[and_bit_idx(N_IN, p, i, 1)];
        end

        AST_EMPTY_TERM: assert property (@(posedge clk) disable iff (!rst_n)
            ((true_sel | inv_sel) == '0) |-> pt_vec[p]); // R3

        AST_CONTRA_TERM: assert property (@(posedge clk) disable iff (!rst_n)
            (|(true_sel & inv_sel)) |-> !pt_vec[p]); // R4

        AST_LITERAL_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
            (|((true_sel & ~pla_in) | (inv_sel & pla_in))) |-> !pt_vec[p]); // R2
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out_chk
        logic [N_PT-1:0] col;
        for (genvar p = 0; p < N_PT; p++) begin : g_col_chk
            assign col[p] = cfg_bits[or_bit_idx(N_IN, N_PT, o, p)];
        end

        AST_EMPTY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            (col == '0) |-> !pla_out[o]); // R6

        AST_TERM_REACHES: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_en && |(col & pt_vec)) |-> pla_out[o]); // R5

        AST_NO_STRAY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            (pla_out[o]) |-> |(col & pt_vec)); // R5
    end

endmodule

bind cfg_pla pla_checker #(
    .N_IN  (N_IN),
    .N_PT  (N_PT),
    .N_OUT (N_OUT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_si   (cfg_si),
    .pla_in   (pla_in),
    .pla_out  (pla_out),
    .cfg_bits (cfg_bits),
    .pt_vec   (pt_vec)
);

// File: tb/cfg_pla_tb.sv
`timescale 1ns/1ps
module cfg_pla_tb;

    localparam int NI = 3;
    localparam int NP = 5;
    localparam int NO = 4;
    localparam int AW = NP * 2 * NI;
    localparam int CW = AW + NO * NP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic          cfg_si = 1'b0;
    logic [NI-1:0] pla_in = '0;
    logic [NO-1:0] pla_out;

    int n_checks = 0;
    int n_fails  = 0;
    logic [CW-1:0] img;

    always #2.5 clk = ~clk;

    cfg_pla #(.N_IN(NI), .N_PT(NP), .N_OUT(NO)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_si  (cfg_si),
        .pla_in  (pla_in),
        .pla_out (pla_out)
    );

    // Reference model built from the index rules in R2 and R5.
    function automatic logic [NO-1:0] ref_eval(input logic [CW-1:0] c,
                                              input logic [NI-1:0] x);
        logic [NP-1:0] t;
        logic [NO-1:0] r;
        for (int p = 0; p < NP; p++) begin
            t[p] = 1'b1;
            for (int i = 0; i < NI; i++) begin
                if (c[p*2*NI + 2*i] && !x[i]) t[p] = 1'b0;
                if (c[p*2*NI + 2*i + 1] && x[i]) t[p] = 1'b0;
            end
        end
        for (int o = 0; o < NO; o++) begin
            r[o] = 1'b0;
            for (int p = 0; p < NP; p++) begin
                if (c[AW + o*NP + p] && t[p]) r[o] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic set_lit(input int p, input int i, input int neg);
        img[p*2*NI + 2*i + neg] = 1'b1;
    endtask

    task automatic set_col(input int o, input int p);
        img[AW + o*NP + p] = 1'b1;
    endtask

    task automatic check(input string tag, input logic [NO-1:0] act,
                         input logic [NO-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: pla_out=%b expected=%b (in=%b)", tag, act, exp, pla_in);
        end
    endtask

    task automatic sweep(input string tag);
        for (int v = 0; v < (1 << NI); v++) begin
            @(negedge clk);
            pla_in = v[NI-1:0];
            #1;
            check(tag, pla_out, ref_eval(img, pla_in));
        end
    endtask

    // Shifts img in, index 0 first (R8); checks muting midway (R9).
    task automatic load_img();
        @(negedge clk);
        cfg_en = 1'b1;
        pla_in = '1;
        for (int k = 0; k < CW; k++) begin
            cfg_si = img[k];
            if (k == CW / 2) begin
                #1;
                check("R9 mute during load", pla_out, '0);
            end
            @(negedge clk);
        end
        cfg_en = 1'b0;
        cfg_si = 1'b0;
    endtask

    task automatic t_reset_state();
        img = '0;
        sweep("R10 reset state");
    endtask

    // Three functions sharing the term in0 & ~in2.
    task automatic t_shared_sop();
        img = '0;
        set_lit(0, 0, 1); set_lit(0, 1, 1);                  // ~a ~b
        set_lit(1, 0, 0); set_lit(1, 2, 1);                  // a ~c (shared)
        set_lit(2, 1, 0); set_lit(2, 2, 0);                  // b c
        set_lit(3, 0, 0); set_lit(3, 1, 0); set_lit(3, 2, 0); // a b c
        set_col(0, 0); set_col(0, 1);
        set_col(1, 1); set_col(1, 2);
        set_col(2, 1); set_col(2, 3);
        load_img();
        sweep("R2 R5 R7 shared SOP");
        @(negedge clk);
        pla_in = 3'b001;
        #1;
        check("R7 shared term drives three outputs", pla_out, 4'b0111);
        pla_in = 3'b110;
        #1;
        check("R6 empty column stays 0", pla_out, 4'b0010);
    endtask

    task automatic t_corner_terms();
        img = '0;
        set_lit(1, 0, 0); set_lit(1, 0, 1); // contradiction
        set_lit(2, 2, 1);                   // ~in2 alone
        set_col(0, 0);
        set_col(1, 1);
        set_col(2, 2);
        set_col(3, 0); set_col(3, 1);
        load_img();
        sweep("R1 R3 R4 corner terms");
        @(negedge clk);
        pla_in = 3'b011;
        #1;
        check("R3 R4 R1 in=011", pla_out, 4'b1101);
        pla_in = 3'b100;
        #1;
        check("R1 inverted literal in=100", pla_out, 4'b1001);
    endtask

    task automatic t_bit_order();
        for (int o = 0; o < NO; o++) begin
            img = '0;
            set_col(o, (o + 1) % NP);
            load_img();
            @(negedge clk);
            pla_in = '0;
            #1;
            check("R8 output column position", pla_out, 4'(1 << o));
        end
        img = '0;
        set_lit(2, 1, 0);
        set_col(0, 2);
        load_img();
        @(negedge clk);
        pla_in = 3'b010;
        #1;
        check("R8 literal position in=010", pla_out, 4'b0001);
        pla_in = 3'b101;
        #1;
        check("R8 literal position in=101", pla_out, 4'b0000);
    endtask

    task automatic t_retain();
        img = '0;
        set_lit(0, 0, 0); set_lit(0, 2, 0);
        set_lit(4, 1, 1);
        set_col(0, 0); set_col(1, 4); set_col(2, 0); set_col(2, 4);
        set_col(3, 2);
        load_img();
        sweep("R11 immediate after load");
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            cfg_si = k[0] ^ k[2];
        end
        cfg_si = 1'b0;
        sweep("R11 retained with enable low");
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        pla_in = 3'b101;
        rst_n = 1'b0;
        #1;
        check("R10 async clear", pla_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
        img = '0;
        sweep("R10 cleared after reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_shared_sop();
        t_corner_terms();
        t_bit_order();
        t_retain();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule